// File: doc/BRIEF.md
# Spectrum Plot and Waterfall Pixel Renderer

This block turns the position of the raster scan into an 8-bit red, green and blue value for a 640x480, 60 Hz video DAC. A separate raster timer supplies free-running horizontal and vertical counters and a blank flag. Storing a full 24-bit frame would take close to a megabyte, which does not fit on chip. The renderer therefore keeps only compact per-column spectrum data and works out each pixel's colour as the scan reaches it.

An analyser loads one spectrum update as 640 column writes. Each write carries a trace height for the live plot and an 8-bit magnitude for the spectrogram. In plot mode, each column shows a vertical bar whose top is set by its stored height. In waterfall mode, a circular store keeps the 25 most recent updates, sampled every 8th column. The newest update is at the top of the screen, each update row is 4 lines tall, and the magnitude sets the colour. A finished update becomes visible only at the start of vertical blanking, so a frame never shows a mix of two updates.

Top module: `spec_renderer`

## Requirements
- R1: While the blank input is high, red, green and blue are all zero.
- R2: The colour on the outputs belongs to the counter, blank and mode values presented exactly 2 clock cycles earlier.
- R3: In plot mode (`disp_mode`=0), a pixel at line y in column x is lit (0,255,0) when y + height(x) >= 479. Any other visible pixel shows the background (0,0,64).
- R4: A write with `wr_en`=1 stores `wr_height` and `wr_mag` for column `wr_col`. A write to column 639 completes an update.
- R5: A completed update is held back until the next cycle with vcnt=480 and hcnt=0, and only then replaces the displayed data. Until that cycle the previous update stays on screen.
- R6: In waterfall mode (`disp_mode`=1), line y < 100 shows update age y/4 (age 0 is the newest). Column x uses the magnitude m written to column (x/8)*8, and the colour is (m, m/2, 255-m).
- R7: In waterfall mode, lines 100 and below are black.
- R8: The history is circular with 25 visible ages. Each swap moves every update one age further down, and an update older than age 24 is no longer shown.
- R9: After reset, the outputs are zero and the display state is idle until the first swap.
- R10: `disp_mode` selects plot or waterfall per pixel, and both modes draw from the same loaded updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_mode | input | 1 | 0 plot, 1 waterfall |
| hcnt | input | 11 | Horizontal pixel counter |
| vcnt | input | 11 | Vertical line counter |
| blank | input | 1 | High outside the visible area |
| wr_en | input | 1 | Column write strobe |
| wr_col | input | 10 | Column index of the write |
| wr_height | input | 9 | Plot height, 0 to 479 |
| wr_mag | input | 8 | Waterfall magnitude |
| red | output | 8 | Red to DAC |
| green | output | 8 | Green to DAC |
| blue | output | 8 | Blue to DAC |

## Verification
A pixel's colour appears two rising edges after its counters are presented. The bench drives the counters on a falling edge, waits for two more falling edges and samples there. New data becomes visible one edge after the swap cycle. The bench therefore waits a full cycle after presenting vcnt=480 and hcnt=0 before probing any pixel. It also probes before each swap to confirm that the old data is still showing.

// File: rtl/spec_pkg.sv
package spec_pkg;
  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  localparam rgb_t TRACE_RGB = '{r: 8'h00, g: 8'hFF, b: 8'h00};
  localparam rgb_t BACK_RGB  = '{r: 8'h00, g: 8'h00, b: 8'h40};
  localparam rgb_t DARK_RGB  = '{r: 8'h00, g: 8'h00, b: 8'h00};

  // bar test: line sits at or below the trace top
  function automatic logic plot_lit(input logic [11:0] line, input logic [11:0] height,
                                    input logic [11:0] last_line);
    return (line + height) >= last_line;
  endfunction

  // magnitude to colour ramp
  function automatic rgb_t heat(input logic [7:0] m);
    rgb_t c;
    c.r = m;
    c.g = {1'b0, m[7:1]};
    c.b = ~m;
    return c;
  endfunction
endpackage

// File: rtl/spec_swap_ctl.sv
module spec_swap_ctl #(
  parameter int H_ACT = 640,
  parameter int V_ACT = 480,
  parameter int CNT_W = 11,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [COL_W-1:0] wr_col,
  input  logic [CNT_W-1:0] hcnt,
  input  logic [CNT_W-1:0] vcnt,
  output logic             swap_ev,
  output logic             pending
);
  logic done_w;
  logic vb_point;

  assign done_w   = wr_en && (wr_col == COL_W'(H_ACT - 1));
  assign vb_point = (vcnt == CNT_W'(V_ACT)) && (hcnt == '0);
  assign swap_ev  = pending && vb_point;

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= done_w | (pending & ~swap_ev);
  end
endmodule

// File: rtl/spec_plot_store.sv
module spec_plot_store #(
  parameter int H_ACT = 640,
  parameter int HGT_W = 9,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [COL_W-1:0] wr_col,
  input  logic [HGT_W-1:0] wr_height,
  input  logic             swap_ev,
  input  logic [COL_W-1:0] rd_col,
  output logic [HGT_W-1:0] rd_height,
  output logic             disp_bank
);
  logic [HGT_W-1:0] mem [2][H_ACT];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_col < COL_W'(H_ACT))) mem[~disp_bank][wr_col] <= wr_height;
    rd_height <= mem[disp_bank][rd_col];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       disp_bank <= 1'b0;
    else if (swap_ev) disp_bank <= ~disp_bank;
  end
endmodule

// File: rtl/spec_wf_store.sv
module spec_wf_store #(
  parameter int BINS  = 80,
  parameter int HIST  = 25,
  parameter int BIN_W = 7,
  localparam int SLOTS  = HIST + 1,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int AGE_W  = $clog2(HIST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_keep,
  input  logic [BIN_W-1:0]  wr_bin,
  input  logic [7:0]        wr_mag,
  input  logic              swap_ev,
  input  logic [BIN_W-1:0]  rd_bin,
  input  logic [AGE_W-1:0]  rd_age,
  output logic [7:0]        rd_mag,
  output logic [SLOT_W-1:0] head
);
  logic [7:0]        mem [SLOTS][BINS];
  logic [SLOT_W-1:0] wr_slot;
  logic [SLOT_W-1:0] rd_slot;
  logic [SLOT_W-1:0] age_s;

  // spare slot beyond the visible ages takes the incoming update
  assign wr_slot = (head == SLOT_W'(SLOTS - 1)) ? '0 : head + 1'b1;
  assign age_s   = SLOT_W'(rd_age);
  assign rd_slot = (head >= age_s) ? head - age_s : head + SLOT_W'(SLOTS) - age_s;

  always_ff @(posedge clk) begin
    if (wr_en && wr_keep) mem[wr_slot][wr_bin] <= wr_mag;
    rd_mag <= mem[rd_slot][rd_bin];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       head <= '0;
    else if (swap_ev) head <= wr_slot;
  end
endmodule

// File: rtl/spec_renderer.sv
module spec_renderer #(
  parameter int H_ACT     = 640,
  parameter int V_ACT     = 480,
  parameter int CNT_W     = 11,
  parameter int HGT_W     = 9,
  parameter int WF_SHIFT  = 3,
  parameter int HIST      = 25,
  parameter int LINE_LOG2 = 2,
  localparam int COL_W    = $clog2(H_ACT),
  localparam int BIN_W    = COL_W - WF_SHIFT,
  localparam int BINS     = H_ACT >> WF_SHIFT,
  localparam int SLOTS    = HIST + 1,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int AGE_W    = $clog2(HIST),
  localparam int WF_LINES = HIST << LINE_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_mode,
  input  logic [CNT_W-1:0] hcnt,
  input  logic [CNT_W-1:0] vcnt,
  input  logic             blank,
  input  logic             wr_en,
  input  logic [COL_W-1:0] wr_col,
  input  logic [HGT_W-1:0] wr_height,
  input  logic [7:0]       wr_mag,
  output logic [7:0]       red,
  output logic [7:0]       green,
  output logic [7:0]       blue
);
  import spec_pkg::*;

  logic              swap_ev, pending_w, bank_w;
  logic [SLOT_W-1:0] head_w;
  logic [HGT_W-1:0]  rd_height;
  logic [7:0]        rd_mag;
  logic [COL_W-1:0]  col_rd;
  logic [BIN_W-1:0]  bin_rd;
  logic [AGE_W-1:0]  age_rd;
  logic              line_in_wf, wr_keep;

  assign col_rd     = (hcnt < CNT_W'(H_ACT)) ? hcnt[COL_W-1:0] : '0;
  assign bin_rd     = col_rd[COL_W-1:WF_SHIFT];
  assign line_in_wf = vcnt < CNT_W'(WF_LINES);
  assign age_rd     = line_in_wf ? AGE_W'(vcnt >> LINE_LOG2) : '0;
  assign wr_keep    = (wr_col[WF_SHIFT-1:0] == '0) && (wr_col < COL_W'(H_ACT));

  spec_swap_ctl #(.H_ACT(H_ACT), .V_ACT(V_ACT), .CNT_W(CNT_W), .COL_W(COL_W)) swap_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_col(wr_col),
    .hcnt(hcnt), .vcnt(vcnt), .swap_ev(swap_ev), .pending(pending_w));

  spec_plot_store #(.H_ACT(H_ACT), .HGT_W(HGT_W), .COL_W(COL_W)) plot_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_col(wr_col), .wr_height(wr_height),
    .swap_ev(swap_ev), .rd_col(col_rd), .rd_height(rd_height), .disp_bank(bank_w));

  spec_wf_store #(.BINS(BINS), .HIST(HIST), .BIN_W(BIN_W)) wf_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_keep(wr_keep),
    .wr_bin(wr_col[COL_W-1:WF_SHIFT]), .wr_mag(wr_mag), .swap_ev(swap_ev),
    .rd_bin(bin_rd), .rd_age(age_rd), .rd_mag(rd_mag), .head(head_w));

  // stage 1: align raster state with the memory read
  logic             blank_q, mode_q, wf_in_q;
  logic [CNT_W-1:0] line_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blank_q <= 1'b1;
      mode_q  <= 1'b0;
      wf_in_q <= 1'b0;
      line_q  <= '0;
    end else begin
      blank_q <= blank;
      mode_q  <= disp_mode;
      wf_in_q <= line_in_wf;
      line_q  <= vcnt;
    end
  end

  // stage 2: colour
  rgb_t pix_d, pix_q;
  always_comb begin
    if (blank_q)      pix_d = DARK_RGB;
    else if (!mode_q) pix_d = plot_lit(12'(line_q), 12'(rd_height), 12'(V_ACT - 1)) ? TRACE_RGB : BACK_RGB;
    else              pix_d = wf_in_q ? heat(rd_mag) : DARK_RGB;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pix_q <= DARK_RGB;
    else        pix_q <= pix_d;
  end

  assign red   = pix_q.r;
  assign green = pix_q.g;
  assign blue  = pix_q.b;

  // R1
  blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(blank, 2) |-> (red == 8'h00 && green == 8'h00 && blue == 8'h00));
  // R3
  plot_palette_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!blank, 2) && $past(!disp_mode, 2)) |->
      ({red, green, blue} == TRACE_RGB || {red, green, blue} == BACK_RGB));
  // R5
  swap_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_w) |-> ($past(vcnt) == CNT_W'(V_ACT) && $past(hcnt) == '0));
  // R8
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(head_w) |->
      head_w == (($past(head_w) == SLOT_W'(SLOTS - 1)) ? '0 : $past(head_w) + 1'b1));
  // R8
  head_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_w < SLOT_W'(SLOTS));
endmodule

// File: tb/spec_renderer_tb.sv
module spec_renderer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, disp_mode, blank, wr_en;
  logic [10:0] hcnt, vcnt;
  logic [9:0] wr_col;
  logic [8:0] wr_height;
  logic [7:0] wr_mag, red, green, blue;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spec_renderer dut_i (.clk(clk), .rst_n(rst_n), .disp_mode(disp_mode), .hcnt(hcnt),
    .vcnt(vcnt), .blank(blank), .wr_en(wr_en), .wr_col(wr_col), .wr_height(wr_height),
    .wr_mag(wr_mag), .red(red), .green(green), .blue(blue));

  // {mode, x, y}
  localparam int NV = 13;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 11'd0,   11'd0},   {1'b0, 11'd5,   11'd470}, {1'b0, 11'd320, 11'd240},
    {1'b0, 11'd639, 11'd479}, {1'b0, 11'd17,  11'd100}, {1'b0, 11'd400, 11'd400},
    {1'b1, 11'd0,   11'd0},   {1'b1, 11'd7,   11'd3},   {1'b1, 11'd8,   11'd4},
    {1'b1, 11'd639, 11'd99},  {1'b1, 11'd333, 11'd50},  {1'b1, 11'd100, 11'd100},
    {1'b1, 11'd200, 11'd479}};

  function automatic int hgt(int col, int k); return (col * 3 + k * 37) % 480; endfunction
  function automatic int mg(int col, int k); return (col * 5 + k * 29) % 256; endfunction

  function automatic logic [23:0] exp_plot(int x, int y, int k);
    return (y + hgt(x, k) >= 479) ? 24'h00FF00 : 24'h000040;
  endfunction

  function automatic logic [23:0] exp_wf(int x, int y, int newest);
    int m;
    if (y >= 100) return 24'h0;
    m = mg((x / 8) * 8, newest - y / 4);
    return {8'(m), 8'(m / 2), 8'(255 - m)};
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(string req, logic [23:0] got, logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic pix(input logic m, input int x, input int y, input logic b,
                     output logic [23:0] got);
    @(negedge clk);
    disp_mode = m; hcnt = 11'(x); vcnt = 11'(y); blank = b;
    @(negedge clk);
    @(negedge clk);
    got = {red, green, blue};
  endtask

  task automatic load(int k);
    for (int c = 0; c < 640; c++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_col = 10'(c); wr_height = 9'(hgt(c, k)); wr_mag = 8'(mg(c, k));
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic swap();
    @(negedge clk);
    vcnt = 11'd480; hcnt = 11'd0; blank = 1'b1;
    @(negedge clk);
    vcnt = 11'd0; hcnt = 11'd700;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [23:0] g;
    rst_n = 1'b0; disp_mode = 1'b0; blank = 1'b1; hcnt = 11'd700; vcnt = 11'd0;
    wr_en = 1'b0; wr_col = '0; wr_height = '0; wr_mag = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset output", {red, green, blue}, 24'h0);

    load(0); swap();
    // R3 boundary: column 5 height 15, column 0 height 0
    pix(1'b0, 5, 464, 1'b0, g); check("R3 lit at top", g, 24'h00FF00);
    pix(1'b0, 5, 463, 1'b0, g); check("R3 dark above top", g, 24'h000040);
    pix(1'b0, 0, 479, 1'b0, g); check("R3 zero height bottom", g, 24'h00FF00);
    pix(1'b0, 0, 478, 1'b0, g); check("R3 zero height above", g, 24'h000040);

    // R4 R5: held until swap
    load(1);
    pix(1'b0, 100, 142, 1'b0, g); check("R5 old data before swap", g, exp_plot(100, 142, 0));
    swap();
    pix(1'b0, 100, 142, 1'b0, g); check("R4 new data after swap", g, exp_plot(100, 142, 1));

    // R1 blanking in both modes
    pix(1'b0, 100, 300, 1'b1, g); check("R1 blank plot", g, 24'h0);
    pix(1'b1, 16, 10, 1'b1, g);   check("R1 blank waterfall", g, 24'h0);

    // R2: latency 2, one cycle is not enough
    @(negedge clk); disp_mode = 1'b0; hcnt = 11'd5; vcnt = 11'd470; blank = 1'b1;
    @(negedge clk); blank = 1'b0;
    @(negedge clk); check("R2 still blank at 1 cycle", {red, green, blue}, 24'h0);
    @(negedge clk); check("R2 pixel at 2 cycles", {red, green, blue}, exp_plot(5, 470, 1));

    for (int k = 2; k <= 27; k++) begin load(k); swap(); end
    pix(1'b1, 16, 0, 1'b0, g);   check("R6 newest row", g, exp_wf(16, 0, 27));
    pix(1'b1, 16, 99, 1'b0, g);  check("R8 oldest age 24", g, exp_wf(16, 99, 27));
    pix(1'b1, 16, 100, 1'b0, g); check("R7 below history black", g, 24'h0);

    load(28);
    pix(1'b1, 24, 2, 1'b0, g);  check("R5 waterfall held", g, exp_wf(24, 2, 27));
    swap();
    pix(1'b1, 24, 2, 1'b0, g);  check("R8 shifted newest", g, exp_wf(24, 2, 28));
    pix(1'b1, 24, 98, 1'b0, g); check("R8 drop oldest", g, exp_wf(24, 98, 28));

    // R10 table walk, both modes on the same update
    for (int i = 0; i < NV; i++) begin
      logic [23:0] e;
      pix(VEC[i][22], int'(VEC[i][21:11]), int'(VEC[i][10:0]), 1'b0, g);
      e = VEC[i][22] ? exp_wf(int'(VEC[i][21:11]), int'(VEC[i][10:0]), 28)
                     : exp_plot(int'(VEC[i][21:11]), int'(VEC[i][10:0]), 28);
      check(VEC[i][22] ? "R10 R6 table waterfall" : "R10 R3 table plot", g, e);
    end
    done = 1;
    report();
  end
endmodule